// File: doc/BRIEF.md
# Halfword Dot-Product Accumulator Unit

This unit keeps four signed 64-bit accumulators. Each operation takes two 32-bit operands. Each operand holds two signed 16-bit lanes. The unit forms the two lane products and adds their sum to, or subtracts it from, the accumulator that the operation names. There are two ways to pair the lanes. Straight pairing multiplies low by low and high by high. Crossed pairing multiplies the first operand's low lane by the second operand's high lane, and the first operand's high lane by the second operand's low lane.

The crossed forms also come in a Q15 fractional flavour. In that flavour each product is doubled. When both lanes of a pair hold the most negative value, the doubled product would overflow, so it is replaced by the largest positive 32-bit value. Some Q15 forms also clamp the finished 64-bit total to the signed 32-bit range. Every clamp of either kind raises a sticky flag that belongs to the target accumulator.

Operations enter through a valid/ready handshake. Each operation takes two cycles, one per product. Any accumulator can be read at any time through a combinational read port.

Top module: `dotacc_unit`

## Requirements
- R1: After reset, all four accumulators read zero, `flags` is all zero and `opReady` is high.
- R2: An operation is accepted on a rising edge where `opValid` and `opReady` are both high. `opReady` is low for the next cycle and high again in the cycle after that. The new accumulator value and the new flags can be read after the second rising edge following acceptance.
- R3: Codes 5'b00000 (add) and 5'b00001 (subtract) use straight pairing. The unit adds the 32-bit signed products a[15:0]*b[15:0] and a[31:16]*b[31:16] to the 64-bit accumulator, or subtracts them from it, with 64-bit wraparound. No flag changes.
- R4: Codes 5'b01000 (add) and 5'b01001 (subtract) use crossed pairing, a[15:0]*b[31:16] and a[31:16]*b[15:0], with otherwise the same arithmetic as R3. No flag changes.
- R5: Codes 5'b11000 (add) and 5'b11001 (subtract) use crossed pairing and double each product. There is no saturation, so totals beyond 32 bits are kept in full 64 bits.
- R6: In any Q15 code, a pair in which both lanes are 16'h8000 contributes 32'h7FFFFFFF in place of its doubled product. It also sets the flag of the selected accumulator.
- R7: Codes 5'b11010 (add) and 5'b11011 (subtract) behave as R5. After that, a final total above 64'h7FFFFFFF is clamped to that value, and a total below 64'hFFFFFFFF80000000 is clamped to that value. Either clamp sets the accumulator's flag.
- R8: The flag of accumulator n is bit 16+n of `flags`, and every other bit is zero. Flags are sticky: they stay set until reset.
- R9: Any other code is accepted with the normal timing but changes no accumulator and no flag.
- R10: An operation accepted in the first cycle after an earlier operation's write-back, on the same accumulator, builds on the updated value. Accumulators that are not selected never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| opValid | input | 1 | Operation request |
| opReady | output | 1 | Unit can accept an operation |
| opA | input | 32 | First operand, two signed 16-bit lanes |
| opB | input | 32 | Second operand, two signed 16-bit lanes |
| opAccSel | input | 2 | Target accumulator index |
| opCode | input | 5 | Operation code |
| rdSel | input | 2 | Accumulator chosen for the read port |
| rdData | output | 64 | Selected accumulator, high word over low word |
| flags | output | 32 | Sticky clamp flags, bits 16 to 19 |

## Verification
Acceptance happens on a rising edge. `opReady` must be low at the falling edge just after that edge. The accumulator and flags are due only after the next rising edge, so the bench compares `rdData` and `flags` at the falling edge after the write-back edge, one cycle after it checked `opReady`. Back-to-back sequences present the next operation at the first falling edge where `opReady` is high again. Reading the combined result afterwards therefore confirms that the second operation saw the first one's write-back. An expected-value model in the bench computes every result from the operands and the code.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  localparam int OP_W = 5;

  typedef struct packed {
    logic capture;  // first product, operands latched
    logic commit;   // second product, write-back
  } dotacc_strobe_t;

  typedef struct packed {
    logic legal;
    logic crossed;
    logic q15;
    logic subtract;
    logic saturate;
  } dotacc_mode_t;

  function automatic dotacc_mode_t decodeOp(input logic [OP_W-1:0] code);
    dotacc_mode_t m;
    m = '0;
    case (code)
      5'b00000, 5'b00001, 5'b01000, 5'b01001,
      5'b11000, 5'b11001, 5'b11010, 5'b11011: begin
        m.legal    = 1'b1;
        m.crossed  = code[3];
        m.q15      = code[4];
        m.subtract = code[0];
        m.saturate = code[4] & code[1];
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dotacc_ctrl.sv
module dotacc_ctrl
  import dotacc_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  output logic           opReady,
  output dotacc_strobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_SECOND} ctrl_state_t;
  ctrl_state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (opValid) state <= ST_SECOND;
        ST_SECOND: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign opReady        = (state == ST_IDLE);
  assign strobe.capture = opReady & opValid;
  assign strobe.commit  = (state == ST_SECOND);

  // R2: ready drops for exactly one cycle after acceptance
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !opReady);
  assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opReady |=> opReady);
endmodule

// File: rtl/dotacc_dpath.sv
module dotacc_dpath
  import dotacc_pkg::*;
#(
  parameter int LANE_W    = 16,
  parameter int NUM_ACC   = 4,
  parameter int FLAG_BASE = 16,
  parameter int FLAG_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dotacc_strobe_t             strobe,
  input  logic [2*LANE_W-1:0]        opA,
  input  logic [2*LANE_W-1:0]        opB,
  input  logic [$clog2(NUM_ACC)-1:0] opAccSel,
  input  logic [OP_W-1:0]            opCode,
  input  logic [$clog2(NUM_ACC)-1:0] rdSel,
  output logic [4*LANE_W-1:0]        rdData,
  output logic [FLAG_W-1:0]          flags
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int ACC_W  = 2 * WORD_W;
  localparam int PROD_W = 2 * LANE_W;
  localparam int SEL_W  = $clog2(NUM_ACC);
  localparam logic [LANE_W-1:0] LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  SAT_MAX  = {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  SAT_MIN  = {{(ACC_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic [NUM_ACC-1:0][ACC_W-1:0] accBank;
  logic [NUM_ACC-1:0]            stickyBits;
  logic [LANE_W-1:0]             heldX, heldY;
  logic [SEL_W-1:0]              selReg;
  dotacc_mode_t                  modeReg, liveMode, curMode;
  logic [ACC_W-1:0]              partial;
  logic                          clampFirst;

  logic [LANE_W-1:0]        laneX, laneY;
  logic signed [PROD_W-1:0] xExt, yExt, prodRaw, termVal;
  logic signed [ACC_W-1:0]  termExt, baseVal, sumVal;
  logic [ACC_W-1:0]         finalVal;
  logic                     cornerHit, satHi, satLo, satHit;

  assign liveMode = decodeOp(opCode);
  assign curMode  = strobe.commit ? modeReg : liveMode;

  // one shared multiplier: live low lane first, held high lane second
  always_comb begin
    if (strobe.commit) begin
      laneX = heldX;
      laneY = heldY;
    end else begin
      laneX = opA[LANE_W-1:0];
      laneY = liveMode.crossed ? opB[WORD_W-1:LANE_W] : opB[LANE_W-1:0];
    end
  end

  always_comb begin
    xExt      = PROD_W'($signed(laneX));
    yExt      = PROD_W'($signed(laneY));
    prodRaw   = xExt * yExt;
    cornerHit = curMode.q15 && (laneX == LANE_MIN) && (laneY == LANE_MIN);
    if (cornerHit)        termVal = $signed(PROD_MAX);
    else if (curMode.q15) termVal = prodRaw <<< 1;
    else                  termVal = prodRaw;
    termExt = ACC_W'(termVal);
    baseVal = strobe.commit ? $signed(partial) : $signed(accBank[opAccSel]);
    sumVal  = curMode.subtract ? (baseVal - termExt) : (baseVal + termExt);
    satHi   = curMode.saturate && (sumVal > $signed(SAT_MAX));
    satLo   = curMode.saturate && (sumVal < $signed(SAT_MIN));
    satHit  = satHi | satLo;
    if (satHi)      finalVal = SAT_MAX;
    else if (satLo) finalVal = SAT_MIN;
    else            finalVal = sumVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accBank    <= '0;
      stickyBits <= '0;
      heldX      <= '0;
      heldY      <= '0;
      selReg     <= '0;
      modeReg    <= '0;
      partial    <= '0;
      clampFirst <= 1'b0;
    end else begin
      if (strobe.capture) begin
        heldX      <= opA[WORD_W-1:LANE_W];
        heldY      <= liveMode.crossed ? opB[LANE_W-1:0] : opB[WORD_W-1:LANE_W];
        selReg     <= opAccSel;
        modeReg    <= liveMode;
        partial    <= sumVal;
        clampFirst <= cornerHit;
      end
      if (strobe.commit && modeReg.legal) begin
        accBank[selReg] <= finalVal;
        if (clampFirst | cornerHit | satHit) stickyBits[selReg] <= 1'b1;
      end
    end
  end

  assign rdData = accBank[rdSel];

  for (genvar fb = 0; fb < FLAG_W; fb++) begin : g_flag
    if (fb >= FLAG_BASE && fb < FLAG_BASE + NUM_ACC) begin : g_live
      assign flags[fb] = stickyBits[fb-FLAG_BASE];
    end else begin : g_zero
      assign flags[fb] = 1'b0;
    end
  end

  // R9 / R10: accumulators move only on a legal write-back
  assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(accBank));
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !modeReg.legal) |=> ($stable(accBank) && $stable(stickyBits)));
  // R7: saturating forms leave the target in the 32-bit signed range
  assert_sat_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && modeReg.legal && modeReg.saturate) |=>
      (($signed(accBank[selReg]) <= $signed(SAT_MAX)) &&
       ($signed(accBank[selReg]) >= $signed(SAT_MIN))));
  // R6: corner pair in the second product raises the flag
  assert_corner_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && modeReg.legal && cornerHit) |=> stickyBits[selReg]);
  // R8: flags never fall
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stickyBits & $past(stickyBits)) == $past(stickyBits)));
  // R3 / R4: integer forms never touch flags
  assert_int_noflag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && modeReg.legal && !modeReg.q15) |=> $stable(stickyBits));
endmodule

// File: rtl/dotacc_unit.sv
module dotacc_unit
  import dotacc_pkg::*;
#(
  parameter int LANE_W    = 16,
  parameter int NUM_ACC   = 4,
  parameter int FLAG_BASE = 16,
  parameter int FLAG_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       opValid,
  output logic                       opReady,
  input  logic [2*LANE_W-1:0]        opA,
  input  logic [2*LANE_W-1:0]        opB,
  input  logic [$clog2(NUM_ACC)-1:0] opAccSel,
  input  logic [OP_W-1:0]            opCode,
  input  logic [$clog2(NUM_ACC)-1:0] rdSel,
  output logic [4*LANE_W-1:0]        rdData,
  output logic [FLAG_W-1:0]          flags
);
  dotacc_strobe_t strobe;

  dotacc_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opReady(opReady),
    .strobe (strobe)
  );

  dotacc_dpath #(
    .LANE_W   (LANE_W),
    .NUM_ACC  (NUM_ACC),
    .FLAG_BASE(FLAG_BASE),
    .FLAG_W   (FLAG_W)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .opAccSel(opAccSel),
    .opCode  (opCode),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .flags   (flags)
  );
endmodule

// File: tb/test_dotacc_unit.sv
`timescale 1ns/1ps
module test_dotacc_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  opAccSel = '0, rdSel = '0;
  logic [4:0]  opCode = '0;
  logic [63:0] rdData;
  logic [31:0] flags;

  int testCnt = 0;
  int failCnt = 0;
  int cycles  = 0;
  longint accM [4];
  bit     flagM [4];

  always #2 clk = ~clk;

  dotacc_unit i_dotacc_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opA(opA), .opB(opB), .opAccSel(opAccSel), .opCode(opCode),
    .rdSel(rdSel), .rdData(rdData), .flags(flags)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCnt++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  function automatic bit isLegal(input logic [4:0] c);
    return c inside {5'b00000, 5'b00001, 5'b01000, 5'b01001,
                     5'b11000, 5'b11001, 5'b11010, 5'b11011};
  endfunction

  function automatic string reqOf(input logic [4:0] c);
    if (!isLegal(c)) return "R9";
    if (c[4] && c[1]) return "R7";
    if (c[4]) return "R5";
    if (c[3]) return "R4";
    return "R3";
  endfunction

  function automatic longint lanePair(input logic [15:0] x, input logic [15:0] y,
                                      input bit q15, inout bit hit);
    longint xs, ys, p;
    xs = longint'($signed(x));
    ys = longint'($signed(y));
    if (q15 && xs == -32768 && ys == -32768) begin
      hit = 1'b1;
      return 64'sh7FFFFFFF;
    end
    p = xs * ys;
    return q15 ? p * 2 : p;
  endfunction

  function automatic void modelOp(input int sel, input logic [31:0] a, input logic [31:0] b,
                                  input logic [4:0] c);
    bit hit = 1'b0;
    bit crossed = c[3];
    bit q15 = c[4];
    longint p0, p1, acc;
    if (!isLegal(c)) return;
    p0 = lanePair(a[15:0],  crossed ? b[31:16] : b[15:0], q15, hit);
    p1 = lanePair(a[31:16], crossed ? b[15:0]  : b[31:16], q15, hit);
    acc = c[0] ? accM[sel] - p0 - p1 : accM[sel] + p0 + p1;
    if (q15 && c[1]) begin
      if (acc > 64'sh7FFFFFFF) begin acc = 64'sh7FFFFFFF; hit = 1'b1; end
      else if (acc < -64'sh80000000) begin acc = -64'sh80000000; hit = 1'b1; end
    end
    accM[sel] = acc;
    if (hit) flagM[sel] = 1'b1;
  endfunction

  function automatic logic [31:0] flagExp();
    logic [31:0] f = '0;
    for (int i = 0; i < 4; i++) f[16+i] = flagM[i];
    return f;
  endfunction

  function automatic logic [15:0] pickLane();
    int r = $urandom % 8;
    if (r == 0) return 16'h8000;
    if (r == 1) return 16'h7FFF;
    if (r == 2) return 16'hFFFF;
    return 16'($urandom);
  endfunction

  task automatic issue(input int sel, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] c);
    @(negedge clk);
    while (!opReady) @(negedge clk);
    opValid = 1'b1; opA = a; opB = b; opAccSel = 2'(sel); opCode = c;
    @(negedge clk);
    testCnt++;
    if (opReady !== 1'b0) begin
      failCnt++;
      $display("FAIL R2 ready after accept: actual %b expected 0", opReady);
    end
    opValid = 1'b0;
    opA = 32'($urandom); opB = 32'($urandom); opCode = 5'($urandom);
    modelOp(sel, a, b, c);
  endtask

  task automatic checkAcc(input int sel, input string req);
    @(negedge clk);
    rdSel = 2'(sel);
    #0.5;
    testCnt++;
    if (rdData !== 64'(accM[sel]) || flags !== flagExp()) begin
      failCnt++;
      $display("FAIL %s acc%0d: actual %h flags %h expected %h flags %h",
               req, sel, rdData, flags, 64'(accM[sel]), flagExp());
    end
  endtask

  task automatic checkAll(input string req);
    for (int s = 0; s < 4; s++) checkAcc(s, req);
  endtask

  initial begin
    logic [4:0] pool [9];
    pool = '{5'b00000, 5'b00001, 5'b01000, 5'b01001, 5'b11000,
             5'b11001, 5'b11010, 5'b11011, 5'b00010};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin accM[i] = 0; flagM[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    testCnt++;
    if (opReady !== 1'b1) begin
      failCnt++;
      $display("FAIL R1 ready: actual %b expected 1", opReady);
    end
    checkAll("R1");

    // R3: straight add, 2*4 + 3*5 = 23, then subtract with negatives
    issue(0, 32'h0003_0002, 32'h0005_0004, 5'b00000);
    checkAcc(0, "R3");
    testCnt++;
    if (rdData !== 64'd23) begin
      failCnt++;
      $display("FAIL R3 direct: actual %h expected %h", rdData, 64'd23);
    end
    issue(1, 32'hFFFE_7FFF, 32'h8000_7FFF, 5'b00001);
    checkAcc(1, "R3");

    // R4: crossed add, 2*5 + 3*4 = 22
    issue(2, 32'h0003_0002, 32'h0005_0004, 5'b01000);
    checkAcc(2, "R4");
    testCnt++;
    if (rdData !== 64'd22) begin
      failCnt++;
      $display("FAIL R4 direct: actual %h expected %h", rdData, 64'd22);
    end
    issue(2, 32'h8000_1234, 32'h7FFF_FF00, 5'b01001);
    checkAcc(2, "R4");

    // R5: Q15 doubling, grow past 32 bits without saturation
    issue(3, 32'h4000_0100, 32'h0200_2000, 5'b11000);
    checkAcc(3, "R5");
    for (int k = 0; k < 4; k++) issue(3, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 5'b11000);
    checkAcc(3, "R5");

    // R6: both pairs at the corner value
    issue(0, 32'h8000_8000, 32'h8000_8000, 5'b11000);
    checkAcc(0, "R6");
    testCnt++;
    if (flags !== 32'h0001_0000) begin
      failCnt++;
      $display("FAIL R8 flag position: actual %h expected %h", flags, 32'h0001_0000);
    end

    // R7: saturation high then low
    for (int k = 0; k < 3; k++) issue(1, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 5'b11010);
    checkAcc(1, "R7");
    testCnt++;
    if (rdData !== 64'h0000_0000_7FFF_FFFF) begin
      failCnt++;
      $display("FAIL R7 upper clamp: actual %h expected %h", rdData, 64'h7FFF_FFFF);
    end
    for (int k = 0; k < 6; k++) issue(2, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 5'b11011);
    checkAcc(2, "R7");
    testCnt++;
    if (rdData !== 64'hFFFF_FFFF_8000_0000) begin
      failCnt++;
      $display("FAIL R7 lower clamp: actual %h expected %h", rdData, 64'hFFFF_FFFF_8000_0000);
    end

    // R9: unsupported code changes nothing
    issue(3, 32'h1234_5678, 32'h7FFF_8000, 5'b00010);
    checkAll("R9");
    issue(3, 32'h8000_8000, 32'h8000_8000, 5'b11100);
    checkAll("R9");

    // R10: back-to-back on one accumulator
    issue(0, 32'h0010_0020, 32'h0030_0040, 5'b00000);
    issue(0, 32'h0100_0200, 32'h0300_0400, 5'b01001);
    issue(0, 32'hFFFF_0001, 32'h0002_8000, 5'b11001);
    checkAll("R10");

    // R8: sticky flags survive later quiet operations
    issue(0, 32'h0001_0001, 32'h0001_0001, 5'b00000);
    checkAcc(0, "R8");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 4;
      logic [4:0] c = ($urandom % 16 == 0) ? 5'($urandom) : pool[$urandom % 8];
      logic [31:0] a = {pickLane(), pickLane()};
      logic [31:0] b = {pickLane(), pickLane()};
      issue(sel, a, b, c);
      if (n % 3 != 0) checkAcc(sel, reqOf(c));
    end
    checkAll("R10");

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule